// File: doc/BRIEF.md
# Event Timer With Single Comparator Channel

This block is a free-running 64-bit event counter paired with one comparator channel. The channel can be armed as a one-shot alarm or as a periodic tick source. Software reaches it through a small register port with separate read and write strobes, a 3-bit address and a 64-bit data path. Each access is either 32 bits wide (data in bits 31:0) or 64 bits wide. When the counter reaches the comparator while the channel is enabled, the block emits a one-cycle interrupt pulse. It also latches a status flag that software clears by writing 1.

The channel can be forced into a narrow 32-bit mode. In that mode the comparator and the counter both behave as 32-bit quantities. Their upper halves read as zero and take part in neither matching nor carries. A set-value flag in the channel configuration steers the next two comparator writes: the first sets the match point, the second sets the period. A system timer can therefore program a periodic tick with two plain writes.

Top module: `evt_timer`

## Requirements
- R1: While the run bit (control register, address 1, bit 0) is 1, the counter rises by exactly one per clock and carries across bit 31 into the upper half. While run is 0 it holds its value. A 64-bit read at address 6 returns all 64 bits.
- R2: Writes to the counter (address 6 for the lower half, or all 64 bits in a 64-bit access; address 7 for the upper half) take effect only while run is 0. While run is 1 they leave the count untouched. A 32-bit write to address 6 keeps the upper half.
- R3: In narrow mode the counter's upper half reads as zero. The lower half wraps from 0xFFFFFFFF to 0 without any carry.
- R4: The identification register (address 0) reads 0x7E510001, with bit 0 reporting a 64-bit counter. Channel configuration (address 3) uses these bits: bit 0 enable, bit 1 periodic, bit 2 set-value, bit 3 force-32, bit 4 channel 64-bit capable (read-only, 1), bit 5 effective narrow mode (read-only). Narrow mode is active when force-32 is 1 or when either capability is absent.
- R5: In periodic mode every match adds the stored period to the comparator (modulo the active width) and produces one interrupt.
- R6: In one-shot mode (periodic bit 0) a match produces one interrupt and leaves the comparator unchanged.
- R7: While the enable bit is 0, neither the interrupt nor the status flag is raised.
- R8: Writing config with bit 2 set has the following effect. The next comparator write (address 4 or 5) loads the comparator, and the one after it loads the period. Bit 2 always reads back as 0.
- R9: A match is the counter equalling the comparator at the active width while run and enable are 1. It gives a one-cycle `irq` pulse one clock later and sets status (address 2) bit 0. Writing 1 to that bit clears it.
- R10: A comparator read returns the value just written. In 64-bit mode a 32-bit write to address 4 changes only the lower half, and address 5 addresses the upper half. In narrow mode the upper half reads as zero.
- R11: In narrow mode, matching is modulo 2^32. A target below the current count matches once the counter wraps past zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; `rdata` updates on the next edge |
| addr | input | 3 | Register address |
| wide | input | 1 | 1 selects a 64-bit access at addresses 4 and 6 |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Registered read data, held between reads |
| irq | output | 1 | One-cycle pulse per comparator match |

## Verification
The assertions take several things for granted about the port.

- At most one of `wr_en` and `rd_en` is high in a cycle.
- Inputs are stable around each rising edge.
- The step and periodic-advance properties apply only in cycles with no counter or comparator write and a constant width mode; their antecedents exclude the other cases.

The stimulus changes inputs only on falling edges and issues one access per cycle. It starts and stops the counter with explicit control writes, so every match lands on a counter value whose timing is known.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_ID     = 3'd0,
        RA_CTRL   = 3'd1,
        RA_STAT   = 3'd2,
        RA_CFG    = 3'd3,
        RA_CMP_LO = 3'd4,
        RA_CMP_HI = 3'd5,
        RA_CNT_LO = 3'd6,
        RA_CNT_HI = 3'd7
    } reg_addr_e;

    localparam int CFG_EN     = 0;
    localparam int CFG_PER    = 1;
    localparam int CFG_SETV   = 2;
    localparam int CFG_F32    = 3;
    localparam int CFG_CAP    = 4;
    localparam int CFG_NARROW = 5;
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         narrow,
    input  logic         ld_lo,
    input  logic         ld_hi,
    input  logic [W/2-1:0] lo_val,
    input  logic [W/2-1:0] hi_val,
    output logic [W-1:0] cnt
);
    localparam int H = W / 2;

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_s;

    cnt_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run) begin
            if (narrow) st_d.cnt[H-1:0] = st_q.cnt[H-1:0] + H'(1);
            else        st_d.cnt        = st_q.cnt + W'(1);
        end else begin
            if (ld_lo) st_d.cnt[H-1:0] = lo_val;
            if (ld_hi) st_d.cnt[W-1:H] = hi_val;
        end
        if (narrow) st_d.cnt[W-1:H] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        run && !narrow |=> cnt == $past(cnt) + W'(1));
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !ld_lo && !ld_hi && !narrow |=> $stable(cnt));
    p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        narrow |=> cnt[W-1:H] == '0);
    p_low_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run && narrow |=> cnt[H-1:0] == $past(cnt[H-1:0]) + H'(1));
endmodule

// File: rtl/evt_channel.sv
module evt_channel #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt,
    input  logic         narrow,
    input  logic         run,
    input  logic         en,
    input  logic         periodic,
    input  logic         arm,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic [W/2-1:0] lo_val,
    input  logic [W/2-1:0] hi_val,
    output logic [W-1:0] cmp,
    output logic         hit
);
    localparam int H = W / 2;

    typedef struct packed {
        logic [W-1:0] cmp;
        logic [W-1:0] prd;
        logic [1:0]   seq;
    } chan_s;

    chan_s st_d, st_q;
    logic  wr_any;
    logic  eq_val;

    assign wr_any = wr_lo | wr_hi;
    assign eq_val = narrow ? (cnt[H-1:0] == st_q.cmp[H-1:0]) : (cnt == st_q.cmp);
    assign hit    = run & en & eq_val;

    always_comb begin
        st_d = st_q;
        if (hit && periodic) st_d.cmp = st_q.cmp + st_q.prd;
        if (wr_any) begin
            if (st_q.seq == 2'd1) begin
                if (wr_lo) st_d.prd[H-1:0] = lo_val;
                if (wr_hi) st_d.prd[W-1:H] = hi_val;
            end else begin
                if (wr_lo) st_d.cmp[H-1:0] = lo_val;
                if (wr_hi) st_d.cmp[W-1:H] = hi_val;
            end
        end
        if (arm)                            st_d.seq = 2'd2;
        else if (wr_any && st_q.seq != 2'd0) st_d.seq = st_q.seq - 2'd1;
        if (narrow) begin
            st_d.cmp[W-1:H] = '0;
            st_d.prd[W-1:H] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmp = st_q.cmp;

    p_periodic_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit && periodic && !wr_any && !narrow |=> cmp == $past(cmp) + $past(st_q.prd));
    p_oneshot_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit && !periodic && !wr_any && !narrow |=> $stable(cmp));
    p_period_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.seq == 2'd1 && wr_any && !hit && !narrow |=> $stable(cmp));
endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int          W         = 64,
    parameter bit          CNT_WIDE  = 1'b1,
    parameter bit          CHAN_WIDE = 1'b1,
    parameter logic [15:0] ID_CODE   = 16'h7E51
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wide,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata,
    output logic              irq
);
    localparam int H = W / 2;

    typedef struct packed {
        logic         run;
        logic         en;
        logic         per;
        logic         f32;
        logic         sticky;
        logic         irq;
        logic [W-1:0] rdata;
    } top_s;

    top_s        st_d, st_q;
    reg_addr_e   ra;
    logic        narrow, hit, arm;
    logic        ld_lo, ld_hi, cw_lo, cw_hi;
    logic [H-1:0] hi_val;
    logic [W-1:0] cnt, cmp, rv;

    assign ra     = reg_addr_e'(addr);
    assign narrow = st_q.f32 | ~(CNT_WIDE & CHAN_WIDE);
    assign arm    = wr_en & (ra == RA_CFG) & wdata[CFG_SETV];
    assign hi_val = (ra == RA_CNT_HI || ra == RA_CMP_HI) ? wdata[H-1:0] : wdata[W-1:H];
    assign ld_lo  = wr_en & ~st_q.run & (ra == RA_CNT_LO);
    assign ld_hi  = wr_en & ~st_q.run & (((ra == RA_CNT_LO) & wide) | (ra == RA_CNT_HI));
    assign cw_lo  = wr_en & (ra == RA_CMP_LO);
    assign cw_hi  = wr_en & (((ra == RA_CMP_LO) & wide) | (ra == RA_CMP_HI));

    evt_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(st_q.run), .narrow(narrow),
        .ld_lo(ld_lo), .ld_hi(ld_hi), .lo_val(wdata[H-1:0]), .hi_val(hi_val),
        .cnt(cnt)
    );

    evt_channel #(.W(W)) u_chan (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .narrow(narrow), .run(st_q.run),
        .en(st_q.en), .periodic(st_q.per), .arm(arm),
        .wr_lo(cw_lo), .wr_hi(cw_hi), .lo_val(wdata[H-1:0]), .hi_val(hi_val),
        .cmp(cmp), .hit(hit)
    );

    always_comb begin
        rv = '0;
        case (ra)
            RA_ID:   rv[31:0] = {ID_CODE, 15'd0, CNT_WIDE};
            RA_CTRL: rv[0] = st_q.run;
            RA_STAT: rv[0] = st_q.sticky;
            RA_CFG: begin
                rv[CFG_EN]     = st_q.en;
                rv[CFG_PER]    = st_q.per;
                rv[CFG_F32]    = st_q.f32;
                rv[CFG_CAP]    = CHAN_WIDE;
                rv[CFG_NARROW] = narrow;
            end
            RA_CMP_LO: begin
                rv[H-1:0] = cmp[H-1:0];
                if (wide && !narrow) rv[W-1:H] = cmp[W-1:H];
            end
            RA_CMP_HI: if (!narrow) rv[H-1:0] = cmp[W-1:H];
            RA_CNT_LO: begin
                rv[H-1:0] = cnt[H-1:0];
                if (wide && !narrow) rv[W-1:H] = cnt[W-1:H];
            end
            RA_CNT_HI: if (!narrow) rv[H-1:0] = cnt[W-1:H];
            default:   rv = '0;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        st_d.irq = hit;
        if (wr_en && ra == RA_CTRL) st_d.run = wdata[0];
        if (wr_en && ra == RA_CFG) begin
            st_d.en  = wdata[CFG_EN];
            st_d.per = wdata[CFG_PER];
            st_d.f32 = wdata[CFG_F32];
        end
        if (hit)                                       st_d.sticky = 1'b1;
        else if (wr_en && ra == RA_STAT && wdata[0])   st_d.sticky = 1'b0;
        if (rd_en) st_d.rdata = rv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;
    assign irq   = st_q.irq;

    p_irq_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> st_q.sticky);
    p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.en |=> !irq);
endmodule

// File: tb/sim_evt_timer.sv
module sim_evt_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, wide = 1'b0;
    logic [2:0]  addr = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        irq;

    int n_cyc = 0, f_cyc = 0, n_dir = 0, f_dir = 0, irq_total = 0, wd = 0;
    string cur_req = "R9";

    // reference model state
    logic [63:0] m_cnt = '0, m_cmp = '0, m_prd = '0, m_rdata = '0;
    logic [63:0] n_cnt, n_cmp, n_prd, tgt, rv;
    logic        m_run = 0, m_en = 0, m_per = 0, m_f32 = 0, m_sticky = 0, m_irq = 0;
    logic        hit_m;
    int          m_seq = 0;

    always #2 clk = ~clk;

    evt_timer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wide(wide), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = '0; m_cmp = '0; m_prd = '0; m_rdata = '0; m_seq = 0;
            m_run = 0; m_en = 0; m_per = 0; m_f32 = 0; m_sticky = 0; m_irq = 0;
        end else begin
            hit_m = m_run && m_en &&
                    (m_f32 ? (m_cnt[31:0] == m_cmp[31:0]) : (m_cnt == m_cmp));
            if (rd_en) begin
                rv = '0;
                case (addr)
                    3'd0: rv = 64'h7E51_0001;
                    3'd1: rv[0] = m_run;
                    3'd2: rv[0] = m_sticky;
                    3'd3: rv = {58'd0, m_f32, 1'b1, m_f32, 1'b0, m_per, m_en};
                    3'd4: rv = (wide && !m_f32) ? m_cmp : {32'd0, m_cmp[31:0]};
                    3'd5: rv = m_f32 ? 64'd0 : {32'd0, m_cmp[63:32]};
                    3'd6: rv = (wide && !m_f32) ? m_cnt : {32'd0, m_cnt[31:0]};
                    default: rv = m_f32 ? 64'd0 : {32'd0, m_cnt[63:32]};
                endcase
                m_rdata = rv;
            end
            n_cnt = m_cnt;
            if (m_run) begin
                if (m_f32) n_cnt = {32'd0, m_cnt[31:0] + 32'd1};
                else       n_cnt = m_cnt + 64'd1;
            end else if (wr_en && addr == 3'd6) begin
                n_cnt[31:0] = wdata[31:0];
                if (wide) n_cnt[63:32] = wdata[63:32];
            end else if (wr_en && addr == 3'd7) begin
                n_cnt[63:32] = wdata[31:0];
            end
            n_cmp = m_cmp; n_prd = m_prd;
            if (hit_m && m_per) n_cmp = m_cmp + m_prd;
            if (wr_en && (addr == 3'd4 || addr == 3'd5)) begin
                tgt = (m_seq == 1) ? n_prd : n_cmp;
                if (addr == 3'd4) begin
                    tgt[31:0] = wdata[31:0];
                    if (wide) tgt[63:32] = wdata[63:32];
                end else begin
                    tgt[63:32] = wdata[31:0];
                end
                if (m_seq == 1) n_prd = tgt; else n_cmp = tgt;
                if (m_seq != 0) m_seq = m_seq - 1;
            end
            if (wr_en && addr == 3'd3 && wdata[2]) m_seq = 2;
            if (m_f32) begin
                n_cnt[63:32] = '0; n_cmp[63:32] = '0; n_prd[63:32] = '0;
            end
            if (hit_m) m_sticky = 1;
            else if (wr_en && addr == 3'd2 && wdata[0]) m_sticky = 0;
            if (wr_en && addr == 3'd1) m_run = wdata[0];
            if (wr_en && addr == 3'd3) begin
                m_en = wdata[0]; m_per = wdata[1]; m_f32 = wdata[3];
            end
            m_irq = hit_m;
            m_cnt = n_cnt; m_cmp = n_cmp; m_prd = n_prd;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            n_cyc++;
            if (irq) irq_total++;
            if (irq !== m_irq || rdata !== m_rdata) begin
                f_cyc++;
                $display("FAIL %s cycle: irq=%0b rdata=%h expected irq=%0b rdata=%h",
                         cur_req, irq, rdata, m_irq, m_rdata);
            end
        end
    end

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd == 20000) begin
            $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", wd);
            $display("== %0d vectors applied, %0d miscompares ==",
                     n_cyc + n_dir + 1, f_cyc + f_dir + 1);
            $finish;
        end
    end

    task automatic bus_wr(input logic [2:0] a, input logic [63:0] d, input logic w);
        wr_en = 1; addr = a; wdata = d; wide = w;
        @(negedge clk);
        wr_en = 0; wide = 0;
    endtask

    task automatic bus_rd(input logic [2:0] a, input logic w);
        rd_en = 1; addr = a; wide = w;
        @(negedge clk);
        rd_en = 0; wide = 0;
    endtask

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_dir++;
        if (got !== exp) begin
            f_dir++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic run_for(input int k);
        bus_wr(3'd1, 64'd1, 0);
        repeat (k) @(negedge clk);
        bus_wr(3'd1, 64'd0, 0);
    endtask

    int base;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R9 reset irq", {63'd0, irq}, 64'd0);
        cur_req = "R4";
        bus_rd(3'd0, 0); chk("R4 id", rdata, 64'h7E51_0001);
        bus_rd(3'd3, 0); chk("R4 cfg reset", rdata, 64'h10);
        bus_rd(3'd1, 0); chk("R1 run reset", rdata, 64'h0);

        cur_req = "R1";
        bus_wr(3'd6, 64'h1_FFFF_FFFE, 1);
        run_for(5);
        bus_rd(3'd6, 1); chk("R1 count carry", rdata, 64'h2_0000_0004);

        cur_req = "R2";
        bus_wr(3'd1, 64'd1, 0);
        bus_wr(3'd6, 64'd0, 1);
        bus_wr(3'd1, 64'd0, 0);
        bus_rd(3'd6, 1); chk("R2 write while running", rdata, 64'h2_0000_0006);
        bus_wr(3'd6, 64'h1234, 0);
        bus_rd(3'd6, 1); chk("R2 lower write", rdata, 64'h2_0000_1234);

        cur_req = "R4";
        bus_wr(3'd3, 64'h8, 0);
        bus_rd(3'd3, 0); chk("R4 narrow cfg", rdata, 64'h38);
        cur_req = "R3";
        bus_rd(3'd6, 1); chk("R3 upper zero", rdata, 64'h1234);
        bus_wr(3'd6, 64'hFFFF_FFFE, 0);
        run_for(2);
        bus_rd(3'd6, 1); chk("R3 wrap", rdata, 64'h1);
        bus_wr(3'd3, 64'h0, 0);
        bus_rd(3'd3, 0); chk("R4 wide cfg", rdata, 64'h10);

        cur_req = "R10";
        bus_wr(3'd4, 64'hAAAA_BBBB_CCCC_DDDD, 1);
        bus_rd(3'd4, 1); chk("R10 readback", rdata, 64'hAAAA_BBBB_CCCC_DDDD);
        bus_wr(3'd4, 64'h1111_2222, 0);
        bus_rd(3'd4, 1); chk("R10 lower only", rdata, 64'hAAAA_BBBB_1111_2222);
        bus_wr(3'd5, 64'h3333_4444, 0);
        bus_rd(3'd5, 0); chk("R10 upper half", rdata, 64'h3333_4444);
        bus_wr(3'd3, 64'h8, 0);
        bus_rd(3'd4, 1); chk("R10 narrow read", rdata, 64'h1111_2222);
        bus_wr(3'd3, 64'h0, 0);

        cur_req = "R6";
        bus_wr(3'd6, 64'd100, 1);
        bus_wr(3'd4, 64'd110, 1);
        bus_wr(3'd3, 64'h1, 0);
        base = irq_total;
        run_for(29);
        chk("R6 one pulse", 64'(irq_total - base), 64'd1);
        bus_rd(3'd4, 1); chk("R6 cmp kept", rdata, 64'd110);
        cur_req = "R9";
        bus_rd(3'd2, 0); chk("R9 sticky set", rdata, 64'd1);
        bus_wr(3'd2, 64'd1, 0);
        bus_rd(3'd2, 0); chk("R9 sticky clear", rdata, 64'd0);

        cur_req = "R7";
        bus_wr(3'd3, 64'h0, 0);
        bus_wr(3'd4, 64'd135, 1);
        base = irq_total;
        run_for(19);
        chk("R7 no irq", 64'(irq_total - base), 64'd0);
        bus_rd(3'd2, 0); chk("R7 no status", rdata, 64'd0);

        cur_req = "R8";
        bus_wr(3'd6, 64'd0, 1);
        bus_wr(3'd3, 64'h7, 0);
        bus_wr(3'd4, 64'd20, 1);
        bus_wr(3'd4, 64'd10, 1);
        bus_rd(3'd3, 0); chk("R8 flag reads 0", rdata, 64'h13);
        bus_rd(3'd4, 1); chk("R8 first write is cmp", rdata, 64'd20);
        cur_req = "R5";
        base = irq_total;
        run_for(59);
        chk("R5 pulse count", 64'(irq_total - base), 64'd4);
        bus_rd(3'd4, 1); chk("R5 cmp advanced", rdata, 64'd60);

        cur_req = "R11";
        bus_wr(3'd3, 64'h9, 0);
        bus_wr(3'd6, 64'hFFFF_FFF8, 0);
        bus_wr(3'd4, 64'd3, 0);
        base = irq_total;
        run_for(14);
        chk("R11 wrapped match", 64'(irq_total - base), 64'd1);

        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_cyc + n_dir, f_cyc + f_dir);
        $finish;
    end
endmodule